// File: doc/BRIEF.md
# Least-Frequently-Used Victim Selector

This block keeps the replacement state of a set-associative cache that evicts the least frequently used way. For every set it stores one saturating use counter per way. The cache controller reports three kinds of event, each carrying a set index and a way number. A hit bumps that way's counter. A fill after a miss clears it. An eviction also clears it. All event updates take effect on the rising clock edge.

To pick a victim, the controller presents a set index together with the valid bits of that set's ways. The chosen way appears on the output in the same cycle, with no clock edge in between. The search keeps way 0 as the first candidate. It then walks the remaining ways in ascending order and stops at the first invalid one it meets. Otherwise the candidate moves only to a strictly smaller count. Tag and data storage and all memory traffic stay in the controller.

Top module: `lfu_victim_sel`

## Requirements
- R1: After reset every counter of every set is zero, so with all ways valid the victim of any set is way 0.
- R2: With all ways of the queried set valid, the victim is the way holding the smallest count; among equal smallest counts the lowest-numbered way is chosen.
- R3: When any way with index 1 or above is invalid (its bit in query_valid, bit i for way i, is 0), the victim is the lowest-numbered such invalid way, regardless of the counts of the ways before it.
- R4: An invalid way 0 is not chosen for being invalid; it stays the candidate only through its count, and a valid way with a strictly lower count displaces it.
- R5: A hit event increments the addressed way's counter in the addressed set by one at the next rising edge; the counters of other ways and other sets keep their values.
- R6: A counter that holds its maximum value (all CNT_W bits set) stays at that value on a further hit instead of wrapping.
- R7: A fill event sets the addressed way's counter to zero at the next rising edge.
- R8: An eviction event sets the addressed way's counter to zero at the next rising edge.
- R9: When a hit and a fill or eviction address the same way of the same set in one cycle, the counter becomes zero; events on different ways in one cycle all take effect.
- R10: victim_way follows changes of query_set and query_valid within the same cycle, with no clock edge required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| hit_en | input | 1 | Hit event strobe |
| hit_set | input | SET_W | Set index of the hit |
| hit_way | input | WAY_W | Way number of the hit |
| fill_en | input | 1 | Fill event strobe |
| fill_set | input | SET_W | Set index of the fill |
| fill_way | input | WAY_W | Way number of the fill |
| evict_en | input | 1 | Eviction event strobe |
| evict_set | input | SET_W | Set index of the eviction |
| evict_way | input | WAY_W | Way number of the eviction |
| query_set | input | SET_W | Set whose victim is requested |
| query_valid | input | NUM_WAYS | Valid bits of the queried set, bit i for way i |
| victim_way | output | WAY_W | Chosen victim way |

## Verification
The hardest state to reach from the ports is a saturated counter that sits next to other counters at distinct, known values. A wrapping counter would then fall below its neighbours and change the victim. The stimulus drives one way past its maximum with a run of hits. It raises the other ways to exactly the maximum, then sweeps every valid mask over that set. A reference model in the bench predicts the victim for every mask, so a wrap, an off-by-one in the tie rule or a mistaken invalid-way rule each shows up as a different victim. Same-cycle hit-and-clear events on one way are also driven to check the priority.

// File: rtl/lfu_pkg.sv
// Package: shared types of the least-frequently-used victim selector.
// Assumes: nothing beyond standard SystemVerilog.
package lfu_pkg;

    // Operation applied to one use counter on the next clock edge.
    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_BUMP  = 2'd1,
        CNT_CLEAR = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/lfu_cnt_cell.sv
// Module: one saturating use counter.
// Does:   holds, increments (stopping at all ones) or clears its count
//         according to the operation code decoded by its owner.
// Assumes: op is stable around the rising edge; reset is synchronous.
module lfu_cnt_cell #(
    parameter int CNT_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  lfu_pkg::cnt_op_e     op,
    output logic [CNT_W-1:0]     count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    // Counter register: clear, saturating increment or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            case (op)
                lfu_pkg::CNT_CLEAR: count_q <= '0;
                lfu_pkg::CNT_BUMP: begin
                    if (count_q != CNT_MAX) begin
                        count_q <= count_q + CNT_W'(1);
                    end
                end
                default: count_q <= count_q;
            endcase
        end
    end

    assign count = count_q;

endmodule

// File: rtl/lfu_event_decode.sv
// Module: event decoder for one set.
// Does:   turns the hit, fill and eviction strobes into one counter
//         operation per way of set SET_ID; a clear outranks a hit.
// Assumes: set and way fields are in range; several events may hit the
//          same set in one cycle.
module lfu_event_decode #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter int SET_ID   = 0,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                   hit_en,
    input  logic [SET_W-1:0]       hit_set,
    input  logic [WAY_W-1:0]       hit_way,
    input  logic                   fill_en,
    input  logic [SET_W-1:0]       fill_set,
    input  logic [WAY_W-1:0]       fill_way,
    input  logic                   evict_en,
    input  logic [SET_W-1:0]       evict_set,
    input  logic [WAY_W-1:0]       evict_way,
    output lfu_pkg::cnt_op_e       ops [NUM_WAYS]
);
    localparam logic [SET_W-1:0] MY_SET = SET_W'(SET_ID);

    logic hit_here;
    logic fill_here;
    logic evict_here;

    // Set match of each event strobe.
    always_comb begin
        hit_here   = hit_en   && (hit_set   == MY_SET);
        fill_here  = fill_en  && (fill_set  == MY_SET);
        evict_here = evict_en && (evict_set == MY_SET);
    end

    for (genvar gw = 0; gw < NUM_WAYS; gw++) begin : g_way
        localparam logic [WAY_W-1:0] MY_WAY = WAY_W'(gw);
        logic clr;
        logic bump;

        // Per-way operation: clearing events win over a hit.
        always_comb begin
            clr  = (fill_here && (fill_way == MY_WAY)) ||
                   (evict_here && (evict_way == MY_WAY));
            bump = hit_here && (hit_way == MY_WAY);
            if (clr) begin
                ops[gw] = lfu_pkg::CNT_CLEAR;
            end else if (bump) begin
                ops[gw] = lfu_pkg::CNT_BUMP;
            end else begin
                ops[gw] = lfu_pkg::CNT_HOLD;
            end
        end
    end

endmodule

// File: rtl/lfu_victim_scan.sv
// Module: combinational victim search over one set.
// Does:   starts with way 0 as candidate, walks ways 1..N-1 upward,
//         stops at the first invalid way, otherwise moves the candidate
//         only to a strictly smaller count.
// Assumes: count and valid belong to the same set.
module lfu_victim_scan #(
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 3,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0][CNT_W-1:0] counts,
    input  logic [NUM_WAYS-1:0]            valid,
    output logic [WAY_W-1:0]               victim
);
    logic [CNT_W-1:0] best_cnt;
    logic             stop;

    // Ascending scan with early exit on an invalid way.
    always_comb begin
        victim   = '0;
        best_cnt = counts[0];
        stop     = 1'b0;
        for (int i = 1; i < NUM_WAYS; i++) begin
            if (!stop) begin
                if (!valid[i]) begin
                    victim = WAY_W'(i);
                    stop   = 1'b1;
                end else if (counts[i] < best_cnt) begin
                    victim   = WAY_W'(i);
                    best_cnt = counts[i];
                end
            end
        end
    end

endmodule

// File: rtl/lfu_victim_sel.sv
// Module: least-frequently-used victim selector (top).
// Does:   keeps NUM_SETS x NUM_WAYS saturating use counters, updates them
//         from hit / fill / eviction events on the clock edge and reports
//         the victim way of query_set combinationally.
// Assumes: set and way fields are in range; synchronous active-low reset.
module lfu_victim_sel #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 3,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit_en,
    input  logic [SET_W-1:0]    hit_set,
    input  logic [WAY_W-1:0]    hit_way,
    input  logic                fill_en,
    input  logic [SET_W-1:0]    fill_set,
    input  logic [WAY_W-1:0]    fill_way,
    input  logic                evict_en,
    input  logic [SET_W-1:0]    evict_set,
    input  logic [WAY_W-1:0]    evict_way,
    input  logic [SET_W-1:0]    query_set,
    input  logic [NUM_WAYS-1:0] query_valid,
    output logic [WAY_W-1:0]    victim_way
);
    logic [NUM_SETS-1:0][NUM_WAYS-1:0][CNT_W-1:0] all_cnt;
    logic [NUM_WAYS-1:0][CNT_W-1:0]               set_cnt;

    for (genvar gs = 0; gs < NUM_SETS; gs++) begin : g_set
        lfu_pkg::cnt_op_e ops [NUM_WAYS];

        lfu_event_decode #(
            .NUM_SETS (NUM_SETS),
            .NUM_WAYS (NUM_WAYS),
            .SET_ID   (gs)
        ) u_dec (
            .hit_en    (hit_en),
            .hit_set   (hit_set),
            .hit_way   (hit_way),
            .fill_en   (fill_en),
            .fill_set  (fill_set),
            .fill_way  (fill_way),
            .evict_en  (evict_en),
            .evict_set (evict_set),
            .evict_way (evict_way),
            .ops       (ops)
        );

        for (genvar gw = 0; gw < NUM_WAYS; gw++) begin : g_way
            lfu_cnt_cell #(
                .CNT_W (CNT_W)
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .op    (ops[gw]),
                .count (all_cnt[gs][gw])
            );
        end
    end

    // Read port: counters of the queried set.
    always_comb begin
        set_cnt = all_cnt[query_set];
    end

    lfu_victim_scan #(
        .NUM_WAYS (NUM_WAYS),
        .CNT_W    (CNT_W)
    ) u_scan (
        .counts (set_cnt),
        .valid  (query_valid),
        .victim (victim_way)
    );

endmodule

// File: rtl/lfu_victim_sel_chk.sv
// Module: property checker for lfu_victim_sel, bound to every instance.
// Does:   relates the event ports, the read-out counters of the queried
//         set and the victim output over time.
// Assumes: attached through the bind statement at the end of this file.
module lfu_victim_sel_chk #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 3,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           hit_en,
    input logic [SET_W-1:0]               hit_set,
    input logic [WAY_W-1:0]               hit_way,
    input logic                           fill_en,
    input logic [SET_W-1:0]               fill_set,
    input logic [WAY_W-1:0]               fill_way,
    input logic                           evict_en,
    input logic [SET_W-1:0]               evict_set,
    input logic [WAY_W-1:0]               evict_way,
    input logic [SET_W-1:0]               query_set,
    input logic [NUM_WAYS-1:0]            query_valid,
    input logic [NUM_WAYS-1:0][CNT_W-1:0] set_cnt,
    input logic [WAY_W-1:0]               victim_way
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic hit_cleared;

    // A hit whose way is also cleared in the same cycle.
    always_comb begin
        hit_cleared = (fill_en && fill_set == hit_set && fill_way == hit_way) ||
                      (evict_en && evict_set == hit_set && evict_way == hit_way);
    end

    assert_victim_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(victim_way) < NUM_WAYS);

    assert_fill_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_set == query_set) |=>
        ($stable(query_set) -> set_cnt[$past(fill_way)] == '0));

    assert_evict_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_en && evict_set == query_set) |=>
        ($stable(query_set) -> set_cnt[$past(evict_way)] == '0));

    assert_hit_bump_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && hit_set == query_set && !hit_cleared &&
         set_cnt[hit_way] != CNT_MAX) |=>
        ($stable(query_set) ->
         set_cnt[$past(hit_way)] == $past(set_cnt[hit_way]) + CNT_W'(1)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && hit_set == query_set && !hit_cleared &&
         set_cnt[hit_way] == CNT_MAX) |=>
        ($stable(query_set) -> set_cnt[$past(hit_way)] == CNT_MAX));

    assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_en && !fill_en && !evict_en) |=>
        ($stable(query_set) -> $stable(set_cnt)));

    for (genvar gw = 0; gw < NUM_WAYS; gw++) begin : g_prop
        localparam logic [WAY_W-1:0] MY_WAY = WAY_W'(gw);

        assert_min_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (&query_valid) |-> (set_cnt[victim_way] <= set_cnt[gw]));

        assert_tie_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ((&query_valid) && (MY_WAY < victim_way)) |->
            (set_cnt[gw] > set_cnt[victim_way]));

        if (gw >= 1) begin : g_inv
            localparam logic [NUM_WAYS-1:0] BELOW =
                ((NUM_WAYS'(1) << gw) - NUM_WAYS'(1)) & ~NUM_WAYS'(1);

            assert_first_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (!query_valid[gw] && ((~query_valid & BELOW) == '0)) |->
                (victim_way == MY_WAY));
        end
    end

endmodule

bind lfu_victim_sel lfu_victim_sel_chk #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .CNT_W    (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_en      (hit_en),
    .hit_set     (hit_set),
    .hit_way     (hit_way),
    .fill_en     (fill_en),
    .fill_set    (fill_set),
    .fill_way    (fill_way),
    .evict_en    (evict_en),
    .evict_set   (evict_set),
    .evict_way   (evict_way),
    .query_set   (query_set),
    .query_valid (query_valid),
    .set_cnt     (set_cnt),
    .victim_way  (victim_way)
);

// File: tb/lfu_victim_sel_bench.sv
`timescale 1ns/100ps
module lfu_victim_sel_bench;
    localparam int NUM_SETS = 16;
    localparam int NUM_WAYS = 4;
    localparam int CNT_W    = 3;
    localparam int SET_W    = 4;
    localparam int WAY_W    = 2;
    localparam int CMAX     = (1 << CNT_W) - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                hit_en = 1'b0, fill_en = 1'b0, evict_en = 1'b0;
    logic [SET_W-1:0]    hit_set = '0, fill_set = '0, evict_set = '0, query_set = '0;
    logic [WAY_W-1:0]    hit_way = '0, fill_way = '0, evict_way = '0;
    logic [NUM_WAYS-1:0] query_valid = '1;
    logic [WAY_W-1:0]    victim_way;

    int checks = 0;
    int fails  = 0;
    int model [NUM_SETS][NUM_WAYS];
    int    exp_q [$];
    string req_q [$];
    event  probe_ev;

    always #2.5 clk = ~clk;

    lfu_victim_sel #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W))
    u_lfu_victim_sel (
        .clk(clk), .rst_n(rst_n),
        .hit_en(hit_en), .hit_set(hit_set), .hit_way(hit_way),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
        .evict_en(evict_en), .evict_set(evict_set), .evict_way(evict_way),
        .query_set(query_set), .query_valid(query_valid), .victim_way(victim_way)
    );

    // Expected victim from the selection rules (R2, R3, R4).
    function automatic int expect_victim(int s, logic [NUM_WAYS-1:0] m);
        int best = 0;
        int low  = model[s][0];
        for (int i = 1; i < NUM_WAYS; i++) begin
            if (!m[i]) return i;
            if (model[s][i] < low) begin
                best = i;
                low  = model[s][i];
            end
        end
        return best;
    endfunction

    // Driver: apply one cycle of events, then update the model (R5-R9).
    task automatic events(input bit he, input int hs, input int hw,
                          input bit fe, input int fs, input int fw,
                          input bit ee, input int es, input int ew);
        @(negedge clk);
        hit_en = he;   hit_set = SET_W'(hs);   hit_way = WAY_W'(hw);
        fill_en = fe;  fill_set = SET_W'(fs);  fill_way = WAY_W'(fw);
        evict_en = ee; evict_set = SET_W'(es); evict_way = WAY_W'(ew);
        @(negedge clk);
        hit_en = 1'b0; fill_en = 1'b0; evict_en = 1'b0;
        if (he && model[hs][hw] < CMAX) model[hs][hw]++;
        if (fe) model[fs][fw] = 0;
        if (ee) model[es][ew] = 0;
        if (he && ((fe && fs == hs && fw == hw) || (ee && es == hs && ew == hw)))
            model[hs][hw] = 0;
    endtask

    task automatic hits(input int s, input int w, input int n);
        for (int k = 0; k < n; k++) events(1, s, w, 0, 0, 0, 0, 0, 0);
    endtask

    // Driver: present a query and push the expected victim.
    task automatic probe(input int s, input logic [NUM_WAYS-1:0] m, input string req);
        @(negedge clk);
        query_set   = SET_W'(s);
        query_valid = m;
        exp_q.push_back(expect_victim(s, m));
        req_q.push_back(req);
        -> probe_ev;
        #2;
    endtask

    task automatic sweep(input int s, input string req);
        for (int m = 0; m < (1 << NUM_WAYS); m++) probe(s, NUM_WAYS'(m), req);
        query_valid = '1;
    endtask

    // Monitor: compare the combinational answer 1 ns after the query (R10).
    initial begin
        forever begin
            @(probe_ev);
            #1;
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL monitor: result with no expected item, actual %0d expected none", victim_way);
            end else begin
                automatic int    e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                checks++;
                if (int'(victim_way) != e) begin
                    fails++;
                    $display("FAIL %s: set %0d valid %b victim actual %0d expected %0d",
                             r, query_set, query_valid, victim_way, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < NUM_SETS; s++)
            for (int w = 0; w < NUM_WAYS; w++) model[s][w] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, all counters zero
        probe(0, 4'b1111, "R1");
        probe(9, 4'b1111, "R1");
        sweep(15, "R1");

        // R2, R5: distinct counts in set 2; set 3 untouched
        hits(2, 0, 2); hits(2, 1, 1); hits(2, 2, 3); hits(2, 3, 1);
        probe(2, 4'b1111, "R2");
        sweep(2, "R2");
        sweep(3, "R5");
        // R4: way 0 invalid, way 1 has strictly lower count -> way 1
        probe(2, 4'b1110, "R4");
        // R3: way 2 invalid stops the scan -> way 2
        probe(2, 4'b1011, "R3");
        probe(2, 4'b0111, "R3");

        // R6: saturation in set 5
        hits(5, 1, 10); hits(5, 0, 7); hits(5, 2, 7); hits(5, 3, 7);
        probe(5, 4'b1111, "R6");
        sweep(5, "R6");
        hits(5, 2, 1);
        events(0, 0, 0, 1, 5, 0, 0, 0, 0);
        sweep(5, "R6");

        // R7: fill clears
        events(0, 0, 0, 1, 2, 2, 0, 0, 0);
        sweep(2, "R7");

        // R8: eviction clears
        hits(5, 0, 3);
        events(0, 0, 0, 0, 0, 0, 1, 5, 3);
        sweep(5, "R8");

        // R9: same-cycle hit and clear on one way, and on separate ways
        hits(7, 0, 4); hits(7, 1, 2); hits(7, 2, 3); hits(7, 3, 5);
        events(1, 7, 0, 1, 7, 0, 0, 0, 0);
        sweep(7, "R9");
        events(1, 7, 1, 0, 0, 0, 1, 7, 2);
        sweep(7, "R9");
        events(1, 7, 3, 0, 0, 0, 1, 7, 3);
        sweep(7, "R9");

        // R10: alternate sets without edges between query and sample
        probe(2, 4'b1111, "R10");
        probe(5, 4'b1111, "R10");
        probe(7, 4'b1101, "R10");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: pending items actual %0d expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule